// File: doc/BRIEF.md
# Multi-Core Pin Output Combiner with Per-Pin Drive Modes

This block merges the output and direction requests of several processor cores onto a bank of I/O pins. Each core offers three vectors per pin: an output-register bit, a peripheral-output bit and a direction bit. A core's output and peripheral bits only count on the pins where that same core asserts direction. The merged result is a wired-OR across cores, so any core can claim a pin without arbitration and without contention.

Each pin holds a mode word, written through a single-pin write port, that shapes the final drive:

- Inverting the output level.
- Inverting the sampled input level.
- Adding a register stage on both the output and input paths.
- Letting the pin float on one level. This gives an open-drain or open-source pin that is toggled through the output bit alone, with direction left asserted.

The block produces a drive-high enable, a drive-low enable and a conditioned input value for each pin. The merge stage and the final drive enables are both registered, so the enables leave from flops.

Top module: `pin_drive_ctrl`

## Requirements
- R1: A pin is driven (drv_hi or drv_lo set) only when at least one core sets its direction bit for that pin. With the all-zero mode word, a pin whose direction is set by any core has exactly one of drv_hi and drv_lo high.
- R2: A core's output-register bit for a pin is masked by that core's own direction bit. The pin level is the OR of all cores' masked contributions; drv_hi shows level 1 and drv_lo shows level 0.
- R3: Within a core, the peripheral-output bit is ORed with the output-register bit before the direction mask. A peripheral bit from a core with direction 0 has no effect.
- R4: Mode bits [5:3] form the high-side field. When that field is 000 a high level drives drv_hi. When it is non-zero, drv_hi stays 0 and the pin floats while the level is high.
- R5: Mode bits [2:0] form the low-side field. When that field is 000 a low level drives drv_lo. When it is non-zero, drv_lo stays 0 and the pin floats while the level is low.
- R6: Mode bit 6 inverts the merged output level before drive decoding.
- R7: Mode bit 7 inverts pad_in before it is presented on pin_in. With bit 7 and bit 8 clear, pin_in follows pad_in in the same cycle.
- R8: Mode bit 8 (clocked I/O) adds one register stage to the output path, giving 3 cycles of latency from the core inputs to the drive enables. It also registers pad_in, so pin_in changes one clock after pad_in.
- R9: After reset every mode word is zero and both drive enables are 0 on every pin.
- R10: With bit 8 clear, a change on the core inputs reaches the drive enables exactly 2 clock edges later. Once the inputs and modes stop changing, the enables stay constant.
- R11: When no core sets direction for a pin, both enables for that pin are 0 whatever its mode word holds.
- R12: drv_hi and drv_lo are never both 1 on the same pin.
- R13: A mode write changes only the pin selected by mode_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_out | input | NUM_CORES x NUM_PINS | Per-core output-register bits |
| core_dir | input | NUM_CORES x NUM_PINS | Per-core direction bits |
| core_per | input | NUM_CORES x NUM_PINS | Per-core peripheral-output bits |
| mode_we | input | 1 | Mode write strobe |
| mode_addr | input | ADDR_W | Pin selected for a mode write |
| mode_wdata | input | 9 | Mode word: [8] clocked, [7] invert in, [6] invert out, [5:3] high side, [2:0] low side |
| pad_in | input | NUM_PINS | Sampled pin levels |
| drv_hi | output | NUM_PINS | Drive-high enables |
| drv_lo | output | NUM_PINS | Drive-low enables |
| pin_in | output | NUM_PINS | Conditioned input values |

## Verification
A fault in the merge register or the final drive flops shows as a wrong or missing enable on the affected pin. It appears two edges after the core inputs change, or three when the pin is in clocked mode. The bench therefore probes each latency at the edge before and the edge after the expected change, so that an extra or missing stage is seen at once.

A corrupted mode word shows only when the pin's level and direction exercise the field involved. For that reason the float, inversion and isolation scenarios place the level on both sides of each field. Whole-bank comparisons against a model built from the requirements catch leakage between pins or cores.

// File: rtl/pin_drive_pkg.sv
package pin_drive_pkg;

    localparam int MODE_W = 9;

    // Per-pin mode word, MSB first: [8] clk_io, [7] inv_in, [6] inv_out,
    // [5:3] hi_sel, [2:0] lo_sel
    typedef struct packed {
        logic       clk_io;
        logic       inv_in;
        logic       inv_out;
        logic [2:0] hi_sel;
        logic [2:0] lo_sel;
    } pin_mode_t;

    // A side is actively driven only for a zero select field
    function automatic logic side_drives(input logic [2:0] sel);
        return (sel == 3'b000);
    endfunction

endpackage

// File: rtl/pin_mode_bank.sv
module pin_mode_bank
    import pin_drive_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  pin_mode_t                wr_data,
    output pin_mode_t [NUM_PINS-1:0] modes
);

    pin_mode_t [NUM_PINS-1:0] modes_d, modes_q;

    always_comb begin
        modes_d = modes_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                modes_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) modes_q <= '0;
        else        modes_q <= modes_d;
    end

    assign modes = modes_q;

endmodule

// File: rtl/core_or_merge.sv
module core_or_merge #(
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_out,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_dir,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_per,
    output logic [NUM_PINS-1:0]                 dir_any,
    output logic [NUM_PINS-1:0]                 out_any
);

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] lvl;
    } merge_s;

    merge_s merge_d, merge_q;
    logic [NUM_CORES-1:0][NUM_PINS-1:0] contrib;

    // Each core's sources are qualified by its own direction bits
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign contrib[c] = (core_out[c] | core_per[c]) & core_dir[c];
    end

    always_comb begin
        merge_d = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            merge_d.dir = merge_d.dir | core_dir[c];
            merge_d.lvl = merge_d.lvl | contrib[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) merge_q <= '0;
        else        merge_q <= merge_d;
    end

    assign dir_any = merge_q.dir;
    assign out_any = merge_q.lvl;

endmodule

// File: rtl/pin_drive_slice.sv
module pin_drive_slice
    import pin_drive_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_t mode,
    input  logic      dir_any,
    input  logic      out_any,
    input  logic      pad_in,
    output logic      drv_hi,
    output logic      drv_lo,
    output logic      pin_in
);

    typedef struct packed {
        logic dir_c;   // optional clocked-I/O stage, direction
        logic lvl_c;   // optional clocked-I/O stage, level
        logic in_c;    // optional clocked-I/O stage, input
        logic hi;      // final drive-high flop
        logic lo;      // final drive-low flop
    } slice_s;

    slice_s st_d, st_q;
    logic   lvl_pre, lvl_sel, dir_sel, in_sel;

    always_comb begin
        // order: merged level -> output inversion -> clocked stage -> decode
        lvl_pre    = out_any ^ mode.inv_out;
        st_d.dir_c = dir_any;
        st_d.lvl_c = lvl_pre;
        st_d.in_c  = pad_in;
        dir_sel    = mode.clk_io ? st_q.dir_c : dir_any;
        lvl_sel    = mode.clk_io ? st_q.lvl_c : lvl_pre;
        st_d.hi    = dir_sel &  lvl_sel & side_drives(mode.hi_sel);
        st_d.lo    = dir_sel & ~lvl_sel & side_drives(mode.lo_sel);
        in_sel     = mode.clk_io ? st_q.in_c : pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drv_hi = st_q.hi;
    assign drv_lo = st_q.lo;
    assign pin_in = in_sel ^ mode.inv_in;

endmodule

// File: rtl/pin_drive_ctrl.sv
module pin_drive_ctrl
    import pin_drive_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 16,
    localparam int ADDR_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_out,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_dir,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_per,
    input  logic                                mode_we,
    input  logic [ADDR_W-1:0]                   mode_addr,
    input  logic [MODE_W-1:0]                   mode_wdata,
    input  logic [NUM_PINS-1:0]                 pad_in,
    output logic [NUM_PINS-1:0]                 drv_hi,
    output logic [NUM_PINS-1:0]                 drv_lo,
    output logic [NUM_PINS-1:0]                 pin_in
);

    pin_mode_t [NUM_PINS-1:0] modes;
    logic [NUM_PINS-1:0]      dir_any, out_any;

    pin_mode_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .wr_addr (mode_addr),
        .wr_data (pin_mode_t'(mode_wdata)),
        .modes   (modes)
    );

    core_or_merge #(.NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_out (core_out),
        .core_dir (core_dir),
        .core_per (core_per),
        .dir_any  (dir_any),
        .out_any  (out_any)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_drive_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (modes[p]),
            .dir_any (dir_any[p]),
            .out_any (out_any[p]),
            .pad_in  (pad_in[p]),
            .drv_hi  (drv_hi[p]),
            .drv_lo  (drv_lo[p]),
            .pin_in  (pin_in[p])
        );
    end

endmodule

// File: rtl/pin_drive_ctrl_chk.sv
module pin_drive_ctrl_chk #(
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 16,
    parameter int ADDR_W    = 4,
    parameter int MODE_W    = 9
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_out,
    input logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_dir,
    input logic [NUM_CORES-1:0][NUM_PINS-1:0]  core_per,
    input logic                                mode_we,
    input logic [ADDR_W-1:0]                   mode_addr,
    input logic [MODE_W-1:0]                   mode_wdata,
    input logic [NUM_PINS-1:0]                 pad_in,
    input logic [NUM_PINS-1:0]                 drv_hi,
    input logic [NUM_PINS-1:0]                 drv_lo,
    input logic [NUM_PINS-1:0]                 pin_in
);

    logic [3:0]          cyc_q;
    logic [3:0]          quiet_q;
    logic [NUM_PINS-1:0] dsel, d1_q, d2_q, d3_q;
    logic [NUM_CORES-1:0][NUM_PINS-1:0] po_q, pd_q, pp_q;
    logic                same_in;

    always_comb begin
        dsel = '0;
        for (int c = 0; c < NUM_CORES; c++) dsel = dsel | core_dir[c];
        same_in = (core_out == po_q) && (core_dir == pd_q) &&
                  (core_per == pp_q) && !mode_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            quiet_q <= '0;
            d1_q    <= '0;
            d2_q    <= '0;
            d3_q    <= '0;
            po_q    <= '0;
            pd_q    <= '0;
            pp_q    <= '0;
        end else begin
            if (cyc_q != 4'hF) cyc_q <= cyc_q + 4'd1;
            if (!same_in)             quiet_q <= '0;
            else if (quiet_q != 4'hF) quiet_q <= quiet_q + 4'd1;
            d1_q <= dsel;
            d2_q <= d1_q;
            d3_q <= d2_q;
            po_q <= core_out;
            pd_q <= core_dir;
            pp_q <= core_per;
        end
    end

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_hi & drv_lo) == '0); // R12

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < 4'd2) |-> (drv_hi == '0 && drv_lo == '0)); // R9

    AST_FLOAT_NO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd3) |-> (((drv_hi | drv_lo) & ~(d2_q | d3_q)) == '0)); // R11

    AST_STEADY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q >= 4'd4) |-> ($stable(drv_hi) && $stable(drv_lo))); // R10

endmodule

bind pin_drive_ctrl pin_drive_ctrl_chk #(
    .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .MODE_W(9)
) u_chk (.*);

// File: tb/pin_drive_ctrl_bench.sv
module pin_drive_ctrl_bench;

    localparam int NC = 4;
    localparam int NP = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                   rst_n;
    logic [NC-1:0][NP-1:0]  c_out, c_dir, c_per;
    logic                   mode_we;
    logic [3:0]             mode_addr;
    logic [8:0]             mode_wdata;
    logic [NP-1:0]          pad_in, drv_hi, drv_lo, pin_in;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [8:0] bmode [NP];

    pin_drive_ctrl #(.NUM_CORES(NC), .NUM_PINS(NP)) u_pin_drive_ctrl (
        .clk(clk), .rst_n(rst_n), .core_out(c_out), .core_dir(c_dir),
        .core_per(c_per), .mode_we(mode_we), .mode_addr(mode_addr),
        .mode_wdata(mode_wdata), .pad_in(pad_in), .drv_hi(drv_hi),
        .drv_lo(drv_lo), .pin_in(pin_in)
    );

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model from the requirements (non-clocked, steady state)
    function automatic logic [NP-1:0] m_hi();
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            logic d, l;
            d = 1'b0; l = 1'b0;
            for (int c = 0; c < NC; c++) begin
                d = d | c_dir[c][p];
                l = l | ((c_out[c][p] | c_per[c][p]) & c_dir[c][p]);
            end
            l = l ^ bmode[p][6];
            r[p] = d & l & (bmode[p][5:3] == 3'b000);
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] m_lo();
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            logic d, l;
            d = 1'b0; l = 1'b0;
            for (int c = 0; c < NC; c++) begin
                d = d | c_dir[c][p];
                l = l | ((c_out[c][p] | c_per[c][p]) & c_dir[c][p]);
            end
            l = l ^ bmode[p][6];
            r[p] = d & ~l & (bmode[p][2:0] == 3'b000);
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] m_in();
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) r[p] = pad_in[p] ^ bmode[p][7];
        return r;
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_mode(input int pin, input logic [8:0] val);
        mode_we = 1'b1; mode_addr = 4'(pin); mode_wdata = val;
        @(negedge clk);
        mode_we = 1'b0;
        bmode[pin] = val;
    endtask

    task automatic clear_all();
        c_out = '0; c_dir = '0; c_per = '0; pad_in = '0;
        for (int p = 0; p < NP; p++) if (bmode[p] != 9'd0) wr_mode(p, 9'd0);
        settle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        c_dir = '1; c_out = '1;
        repeat (3) @(negedge clk);
        chk("R9 hi in reset", drv_hi, '0);
        chk("R9 lo in reset", drv_lo, '0);
        rst_n = 1'b1;
        c_dir = '0; c_out = '0;
        pad_in = 16'hA5C3;
        @(negedge clk);
        chk("R9 hi after reset", drv_hi, '0);
        chk("R7 default in path", pin_in, 16'hA5C3);
        settle();
    endtask

    task automatic t_pushpull();
        c_dir[1][3] = 1'b1; c_out[1][3] = 1'b1;
        c_dir[0][4] = 1'b1; c_out[0][4] = 1'b0;
        settle();
        chk("R1 hi", drv_hi, m_hi());
        chk("R1 lo", drv_lo, m_lo());
        chk("R1 pin3 high", drv_hi & 16'h0018, 16'h0008);
        clear_all();
    endtask

    task automatic t_gating();
        c_out[0][5] = 1'b1;                      // core0 no direction
        c_dir[2][5] = 1'b1; c_out[2][5] = 1'b0;  // core2 owns pin 5
        c_dir[3][6] = 1'b1; c_out[1][6] = 1'b1; c_dir[1][6] = 1'b1;
        settle();
        chk("R2 masked out lo", drv_lo, m_lo());
        chk("R2 pin5 low", {drv_hi[5], drv_lo[5]}, 16'b01);
        chk("R2 pin6 high", {drv_hi[6], drv_lo[6]}, 16'b10);
        clear_all();
    endtask

    task automatic t_periph();
        c_dir[2][8] = 1'b1; c_per[2][8] = 1'b1;
        c_per[0][9] = 1'b1; c_dir[3][9] = 1'b1;
        settle();
        chk("R3 periph hi", drv_hi, m_hi());
        chk("R3 pin8 high pin9 low", {drv_hi[8], drv_lo[8], drv_hi[9], drv_lo[9]}, 16'b1001);
        clear_all();
    endtask

    task automatic t_latency();
        c_dir[0][2] = 1'b1; c_out[0][2] = 1'b1;
        @(negedge clk);
        chk("R10 one edge", drv_hi, '0);
        @(negedge clk);
        chk("R10 two edges", drv_hi, 16'h0004);
        settle();
        chk("R10 steady", drv_hi, 16'h0004);
        clear_all();
    endtask

    task automatic t_open_drain();
        wr_mode(7, 9'b000_101_000);
        c_dir[1][7] = 1'b1; c_out[1][7] = 1'b1;
        settle();
        chk("R4 float high", {drv_hi[7], drv_lo[7]}, 16'b00);
        c_out[1][7] = 1'b0;
        settle();
        chk("R4 drive low", {drv_hi[7], drv_lo[7]}, 16'b01);
        clear_all();
    endtask

    task automatic t_open_source();
        wr_mode(10, 9'b000_000_010);
        c_dir[2][10] = 1'b1; c_out[2][10] = 1'b0;
        settle();
        chk("R5 float low", {drv_hi[10], drv_lo[10]}, 16'b00);
        c_out[2][10] = 1'b1;
        settle();
        chk("R5 drive high", {drv_hi[10], drv_lo[10]}, 16'b10);
        clear_all();
    endtask

    task automatic t_float_no_dir();
        wr_mode(11, 9'b001_000_000);
        wr_mode(12, 9'b000_011_001);
        c_out = '1; c_per = '1;
        settle();
        chk("R11 hi no dir", drv_hi, '0);
        chk("R11 lo no dir", drv_lo, '0);
        clear_all();
    endtask

    task automatic t_inv();
        wr_mode(13, 9'b001_000_000);
        c_dir[0][13] = 1'b1; c_out[0][13] = 1'b1;
        c_dir[0][14] = 1'b1; c_out[0][14] = 1'b1;
        settle();
        chk("R6 inverted out", {drv_hi[13], drv_lo[13], drv_hi[14], drv_lo[14]}, 16'b0110);
        chk("R12 no contention", drv_hi & drv_lo, '0);
        wr_mode(2, 9'b010_000_000);
        pad_in = 16'h0006;
        #1;
        chk("R7 inverted in", pin_in, m_in());
        chk("R7 pin2 inverted", {pin_in[2], pin_in[1]}, 16'b01);
        clear_all();
    endtask

    task automatic t_clocked();
        wr_mode(9, 9'b100_000_000);
        c_dir[3][9] = 1'b1; c_out[3][9] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 not yet at two", drv_hi[9], 1'b0);
        @(negedge clk);
        chk("R8 out at three", drv_hi[9], 1'b1);
        pad_in[9] = 1'b1;
        #1;
        chk("R8 in held", pin_in[9], 1'b0);
        @(negedge clk);
        chk("R8 in after edge", pin_in[9], 1'b1);
        clear_all();
    endtask

    task automatic t_isolation();
        c_dir[0][4] = 1'b1; c_out[0][4] = 1'b1;
        c_dir[0][5] = 1'b1; c_out[0][5] = 1'b1;
        settle();
        wr_mode(4, 9'b000_110_000);
        settle();
        chk("R13 only pin4 floats", drv_hi, 16'h0020);
        chk("R13 model", drv_hi | drv_lo, m_hi() | m_lo());
        clear_all();
    endtask

    initial begin
        for (int p = 0; p < NP; p++) bmode[p] = 9'd0;
        mode_we = 1'b0; mode_addr = '0; mode_wdata = '0;
        c_out = '0; c_dir = '0; c_per = '0; pad_in = '0;
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_pushpull();
        t_gating();
        t_periph();
        t_latency();
        t_open_drain();
        t_open_source();
        t_float_no_dir();
        t_inv();
        t_clocked();
        t_isolation();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule